// File: doc/BRIEF.md
# Secure-Exit Instruction Fault Checker

This block decides the outcome of an instruction that leaves a measured secure environment. It does so before any part of the exit sequence starts. When an issue strobe arrives with the exit leaf selected, the block checks the decoded prefixes and a snapshot of processor state. That snapshot covers the control-register enables, privilege level, virtualization mode, boot-processor designation, chipset presence, the secure-environment and authenticated-code flags, and system-management mode. From these the block picks one outcome from a fixed priority order.

There are four outcomes: invalid-opcode, VM exit, general-protection fault (error code zero) and proceed. Each is coded in two bits. The result is registered and a one-cycle done pulse marks it. The result then holds until the next accepted issue. Decode, fault delivery and the exit handshake itself belong to neighbouring logic.

Top module: `sx_exit_check`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `done_o` is 0 and `result_o` is 2'b00.
- R2: An issue strobe whose `leaf_i` is not equal to 5 gives no done pulse and leaves `result_o` unchanged.
- R3: Prefix bits `pfx_i[0]` (LOCK), `pfx_i[1]` (any REP/REPNE) and `pfx_i[2]` (operand size) each force the result 2'b01 (invalid-opcode), whatever any other input is.
- R4: Prefix bits `pfx_i[3]` (segment override), `pfx_i[4]` (address size) and `pfx_i[5]` (REX) never change the result.
- R5: With no faulting prefix, a clear secure-extensions enable (`ext_en_i`=0) gives 2'b01.
- R6: With the enable set and virtualization active as a guest (`virt_on_i`=1, `virt_guest_i`=1), the result is 2'b11 (VM exit). This takes priority over the support check and over every protection-fault condition.
- R7: Otherwise, a leaf reported as unsupported (`leaf_ok_i`=0) gives 2'b01.
- R8: Otherwise, the result is 2'b10 (protection fault, error code 0) if any of these holds: virtualization host mode (`virt_on_i`=1 with `virt_guest_i`=0), `prot_en_i`=0, `cpl_i`≠0, `v86_i`=1, `boot_cpu_i`=0, `chipset_i`=0, `secure_on_i`=0, `auth_mode_i`=1, or `smm_i`=1.
- R9: When no condition above fires, the result is 2'b00 (proceed).
- R10: An issue with leaf 5 in cycle N gives `done_o`=1 and its result on `result_o` in cycle N+1. `done_o` is 0 in any cycle not preceded by such an issue, and `result_o` holds its value until the next accepted issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction issue strobe |
| leaf_i | input | LEAF_W (32) | Leaf selector value |
| pfx_i | input | 6 | Decoded prefix flags (bit map in R3, R4) |
| ext_en_i | input | 1 | Secure-extensions enable bit of control register 4 |
| leaf_ok_i | input | 1 | Exit leaf reported as supported |
| virt_on_i | input | 1 | Virtualization operation active |
| virt_guest_i | input | 1 | Running as virtualization guest (non-root) |
| prot_en_i | input | 1 | Protected mode enabled |
| cpl_i | input | 2 | Current privilege level |
| v86_i | input | 1 | Virtual-8086 flag |
| boot_cpu_i | input | 1 | Boot-processor designation bit |
| chipset_i | input | 1 | Secure-capable chipset present |
| secure_on_i | input | 1 | Secure environment active flag |
| auth_mode_i | input | 1 | Authenticated-code mode flag |
| smm_i | input | 1 | System-management mode |
| done_o | output | 1 | One-cycle pulse: new result valid |
| result_o | output | 2 | 00 proceed, 01 invalid-opcode, 10 protection fault, 11 VM exit |

## Verification
Every decision passes through one register, so a result is due exactly one cycle after its issue. The bench drives each stimulus on a falling edge and samples `done_o` and `result_o` on the next falling edge. By then exactly one rising edge has passed. The hold and ignored-leaf checks sample over several idle falling edges afterwards. They confirm that no pulse appears and that the earlier outcome stays on the port.

// File: rtl/sx_pkg.sv
package sx_pkg;

    typedef enum logic [1:0] {
        RES_GO  = 2'b00,
        RES_UD  = 2'b01,
        RES_GP  = 2'b10,
        RES_VMX = 2'b11
    } sx_result_e;

    localparam int PFX_N      = 6;
    localparam int PFX_LOCK   = 0;
    localparam int PFX_REP    = 1;
    localparam int PFX_OPSZ   = 2;
    localparam int PFX_SEG    = 3;
    localparam int PFX_ASZ    = 4;
    localparam int PFX_REX    = 5;

    localparam logic [PFX_N-1:0] PFX_FAULT_MASK =
        (PFX_N'(1) << PFX_LOCK) | (PFX_N'(1) << PFX_REP) | (PFX_N'(1) << PFX_OPSZ);

    localparam int GP_N = 9;

    typedef struct packed {
        logic       ext_en;
        logic       leaf_ok;
        logic       virt_on;
        logic       virt_guest;
        logic       prot_en;
        logic [1:0] cpl;
        logic       v86;
        logic       boot_cpu;
        logic       chipset;
        logic       secure_on;
        logic       auth_mode;
        logic       smm;
    } sx_mode_t;

    typedef struct packed {
        logic       done;
        sx_result_e result;
    } sx_state_t;

endpackage

// File: rtl/sx_prefix_screen.sv
module sx_prefix_screen
    import sx_pkg::*;
#(
    parameter int               N_PFX = PFX_N,
    parameter logic [N_PFX-1:0] MASK  = PFX_FAULT_MASK
) (
    input  logic [N_PFX-1:0] pfx_i,
    output logic             ud_o
);

    logic [N_PFX-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_PFX; gi++) begin : g_pfx
            assign hit[gi] = pfx_i[gi] & MASK[gi];
        end
    endgenerate

    assign ud_o = |hit;

    // A locked prefix always faults, independent of the mask reduction.
    always_comb begin
        if (pfx_i[PFX_LOCK] && MASK[PFX_LOCK])
            AST_LOCK_FAULTS: assert (ud_o); // R3
    end

endmodule

// File: rtl/sx_mode_screen.sv
module sx_mode_screen
    import sx_pkg::*;
(
    input  sx_mode_t   mode_i,
    input  logic       pfx_ud_i,
    output sx_result_e res_o
);

    logic [GP_N-1:0] gp_vec;
    logic            gp_any;
    logic            guest_mode;

    assign guest_mode = mode_i.virt_on & mode_i.virt_guest;

    always_comb begin
        gp_vec    = '0;
        gp_vec[0] = mode_i.virt_on & ~mode_i.virt_guest;
        gp_vec[1] = ~mode_i.prot_en;
        gp_vec[2] = |mode_i.cpl;
        gp_vec[3] = mode_i.v86;
        gp_vec[4] = ~mode_i.boot_cpu;
        gp_vec[5] = ~mode_i.chipset;
        gp_vec[6] = ~mode_i.secure_on;
        gp_vec[7] = mode_i.auth_mode;
        gp_vec[8] = mode_i.smm;
    end

    assign gp_any = |gp_vec;

    always_comb begin
        if (pfx_ud_i)
            res_o = RES_UD;
        else if (!mode_i.ext_en)
            res_o = RES_UD;
        else if (guest_mode)
            res_o = RES_VMX;
        else if (!mode_i.leaf_ok)
            res_o = RES_UD;
        else if (gp_any)
            res_o = RES_GP;
        else
            res_o = RES_GO;
    end

    always_comb begin
        if (res_o == RES_VMX)
            AST_VMX_ONLY_GUEST: assert (mode_i.ext_en && mode_i.virt_on && mode_i.virt_guest); // R6
        if (res_o == RES_GO)
            AST_GO_CLEAN: assert (mode_i.prot_en && mode_i.cpl == 2'd0 && mode_i.secure_on
                                  && !mode_i.smm && !mode_i.auth_mode); // R9
    end

endmodule

// File: rtl/sx_exit_check.sv
module sx_exit_check
    import sx_pkg::*;
#(
    parameter int LEAF_W    = 32,
    parameter int EXIT_LEAF = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              issue_i,
    input  logic [LEAF_W-1:0] leaf_i,
    input  logic [5:0]        pfx_i,
    input  logic              ext_en_i,
    input  logic              leaf_ok_i,
    input  logic              virt_on_i,
    input  logic              virt_guest_i,
    input  logic              prot_en_i,
    input  logic [1:0]        cpl_i,
    input  logic              v86_i,
    input  logic              boot_cpu_i,
    input  logic              chipset_i,
    input  logic              secure_on_i,
    input  logic              auth_mode_i,
    input  logic              smm_i,
    output logic              done_o,
    output logic [1:0]        result_o
);

    localparam logic [LEAF_W-1:0] LEAF_HIT = LEAF_W'(EXIT_LEAF);

    sx_mode_t   mode;
    logic       pfx_ud;
    logic       accept;
    sx_result_e decide;
    sx_state_t  st_d, st_q;

    always_comb begin
        mode            = '0;
        mode.ext_en     = ext_en_i;
        mode.leaf_ok    = leaf_ok_i;
        mode.virt_on    = virt_on_i;
        mode.virt_guest = virt_guest_i;
        mode.prot_en    = prot_en_i;
        mode.cpl        = cpl_i;
        mode.v86        = v86_i;
        mode.boot_cpu   = boot_cpu_i;
        mode.chipset    = chipset_i;
        mode.secure_on  = secure_on_i;
        mode.auth_mode  = auth_mode_i;
        mode.smm        = smm_i;
    end

    sx_prefix_screen #(
        .N_PFX (PFX_N),
        .MASK  (PFX_FAULT_MASK)
    ) u_pfx (
        .pfx_i (pfx_i),
        .ud_o  (pfx_ud)
    );

    sx_mode_screen u_mode (
        .mode_i   (mode),
        .pfx_ud_i (pfx_ud),
        .res_o    (decide)
    );

    assign accept = issue_i && (leaf_i == LEAF_HIT);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.done   = 1'b1;
            st_d.result = decide;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.done   <= 1'b0;
            st_q.result <= RES_GO;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign result_o = st_q.result;

    AST_DONE_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> done_o); // R10
    AST_NO_DONE_OTHER_LEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept |=> !done_o); // R2
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept |=> $stable(result_o)); // R10
    AST_PREFIX_UD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && (pfx_i[PFX_LOCK] || pfx_i[PFX_REP] || pfx_i[PFX_OPSZ])) |=> result_o == 2'b01); // R3
    AST_ENABLE_UD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && !ext_en_i) |=> result_o == 2'b01); // R5
    AST_GUEST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && pfx_i[2:0] == 3'b000 && ext_en_i && virt_on_i && virt_guest_i)
        |=> result_o == 2'b11); // R6

endmodule

// File: tb/sx_exit_check_test.sv
`timescale 1ns/1ps
module sx_exit_check_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] leaf = 32'd0;
    logic [5:0]  pfx = 6'd0;
    logic        ext_en = 1'b0, leaf_ok = 1'b0, virt_on = 1'b0, virt_guest = 1'b0;
    logic        prot_en = 1'b0, v86 = 1'b0, boot_cpu = 1'b0, chipset = 1'b0;
    logic        secure_on = 1'b0, auth_mode = 1'b0, smm = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic        done;
    logic [1:0]  result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sx_exit_check uut (
        .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .leaf_i(leaf), .pfx_i(pfx),
        .ext_en_i(ext_en), .leaf_ok_i(leaf_ok), .virt_on_i(virt_on),
        .virt_guest_i(virt_guest), .prot_en_i(prot_en), .cpl_i(cpl), .v86_i(v86),
        .boot_cpu_i(boot_cpu), .chipset_i(chipset), .secure_on_i(secure_on),
        .auth_mode_i(auth_mode), .smm_i(smm), .done_o(done), .result_o(result)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [1:0] model(input logic [15:0] v, output string req);
        logic gp;
        gp = v[4] & ~v[5] | ~v[7] | (v[9:8] != 2'd0) | v[10] | ~v[11] | ~v[12]
             | ~v[13] | v[14] | v[15];
        if (|v[2:0])             begin req = "R3"; return 2'b01; end
        if (!v[3])               begin req = "R5"; return 2'b01; end
        if (v[4] && v[5])        begin req = "R6"; return 2'b11; end
        if (!v[6])               begin req = "R7"; return 2'b01; end
        if (gp)                  begin req = "R8"; return 2'b10; end
        req = "R9";
        return 2'b00;
    endfunction

    task automatic drive_vec(input logic [15:0] v, input logic [2:0] ign, input logic [31:0] lf);
        issue      = 1'b1;
        leaf       = lf;
        pfx        = {ign, v[2:0]};
        ext_en     = v[3];
        virt_on    = v[4];
        virt_guest = v[5];
        leaf_ok    = v[6];
        prot_en    = v[7];
        cpl        = v[9:8];
        v86        = v[10];
        boot_cpu   = v[11];
        chipset    = v[12];
        secure_on  = v[13];
        auth_mode  = v[14];
        smm        = v[15];
    endtask

    localparam logic [15:0] CLEAN = 16'b0011_1000_1100_1000;

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        string req;
        logic [1:0] exp;
        logic [1:0] held;

        repeat (3) @(negedge clk);
        check("R1 done in reset", {1'b0, done}, 2'b00);
        check("R1 result in reset", result, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", {1'b0, done}, 2'b00);
        check("R1 result after reset", result, 2'b00);

        // Exhaustive sweep, back to back: issue on one falling edge, check on the next.
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] v;
            v = 16'(i);
            drive_vec(v, v[2:0] ^ v[15:13] ^ v[9:7], 32'd5);
            @(negedge clk);
            exp = model(v, req);
            check({req, " sweep done (R10)"}, {1'b0, done}, 2'b01);
            check({req, " sweep result"}, result, exp);
        end

        // R4: the ignored prefixes on a clean configuration.
        for (int k = 0; k < 8; k++) begin
            drive_vec(CLEAN, 3'(k), 32'd5);
            @(negedge clk);
            check("R4 ignored prefix", result, 2'b00);
        end

        // Establish a protection-fault result, then hold it while idle.
        drive_vec(CLEAN & ~16'h2000, 3'b000, 32'd5);
        @(negedge clk);
        check("R8 secure flag clear", result, 2'b10);
        issue = 1'b0;
        drive_vec(CLEAN, 3'b000, 32'd5);
        issue = 1'b0;
        held = result;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 no pulse when idle", {1'b0, done}, 2'b00);
            check("R10 result held", result, held);
        end

        // R2: wrong leaf values, with inputs that would otherwise proceed.
        for (int k = 0; k < 8; k++) begin
            drive_vec(CLEAN, 3'b000, (k == 5) ? 32'h8000_0005 : 32'(k));
            @(negedge clk);
            check("R2 no pulse for other leaf", {1'b0, done}, 2'b00);
            check("R2 result unchanged", result, 2'b10);
        end
        issue = 1'b0;

        // R9 then R6 back to back.
        drive_vec(CLEAN, 3'b101, 32'd5);
        @(negedge clk);
        check("R9 proceed", result, 2'b00);
        drive_vec(CLEAN | 16'h0030 | 16'h8000, 3'b000, 32'd5);
        @(negedge clk);
        check("R6 guest over fault", result, 2'b11);
        issue = 1'b0;
        @(negedge clk);
        check("R10 pulse ends", {1'b0, done}, 2'b00);

        finish_run();
    end

endmodule